// File: doc/BRIEF.md
# Isochronous OUT Start-Split Sequencer

This block sits in the high-speed side of a transaction translator. A full-speed isochronous OUT packet reaches it as a series of high-speed start-split pieces, one per microframe. Each piece carries a position tag, which is whole, first, middle or last. For each piece the block decides whether it joins the start-split pipeline, whether it is recorded as a downstream error, or whether it is silently dropped. It keeps a small record for each of a fixed number of endpoints: whether a packet is open, which position was seen last, whether the endpoint was heard in the current microframe, and whether later pieces must be dropped.

The block also watches microframe boundaries. An endpoint whose packet is open and which sent no piece during a whole microframe loses that packet. The full-speed handler is told, through a per-endpoint pulse, to corrupt the packet with a bitstuff error. The endpoint then drops middle and last pieces until the stream resynchronises. A separate pulse marks a rejected whole or first piece, so that no full-speed transaction is started for it.

All results are registered and appear on the cycle after the piece or boundary that caused them.

Top module: `iso_out_ss_seq`

## Requirements
- R1: After reset, all result outputs are 0 and every endpoint is idle with no drop window open. This also holds after a reset asserted while a packet is open: a following middle piece is rejected as an error and is not dropped.
- R2: A whole piece (tag 0) with a valid DATA PID, a good CRC and no timeout is accepted only if its endpoint has no open packet; otherwise it is an error.
- R3: A good first piece (tag 1) is accepted only if its endpoint has no open packet, and it then opens a packet with last position = first; a first piece on an open packet is an error.
- R4: A good middle piece (tag 2) is accepted only if its endpoint has an open packet whose last position is first or middle, and then sets last position = middle; otherwise it is an error.
- R5: A good last piece (tag 3) is accepted only under the same condition as R4, and acceptance closes the packet.
- R6: A bad PID, a bad CRC or a timeout makes the piece an error. Any error closes the endpoint's packet and opens its drop window.
- R7: An error on a whole or first piece also raises `ss_nostart_o`, in the same cycle as `ss_derr_o`.
- R8: While an endpoint's drop window is open, its middle and last pieces raise only `ss_ign_o`. A whole or first piece on any endpoint closes the drop windows of all endpoints.
- R9: At a microframe boundary (`uf_tick`), each endpoint that has an open packet and sent no piece since the previous boundary raises its bit of `fs_bitstuff_o` in the next cycle. That endpoint's packet is closed and its drop window is opened.
- R10: A piece presented in the same cycle as `uf_tick` counts toward the microframe that is ending.
- R11: Endpoints are independent. A piece or a missed boundary affects only the state of its own endpoint, except for the drop-window release in R8.
- R12: Each valid piece yields exactly one of `ss_acc_o`, `ss_derr_o` or `ss_ign_o`, one cycle later. A cycle without a valid piece yields none of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uf_tick | input | 1 | One-cycle pulse at each microframe boundary |
| ss_valid | input | 1 | A start-split piece is presented this cycle |
| ss_ep | input | EP_W | Endpoint slot of the piece |
| ss_part | input | 2 | Position tag: 0 whole, 1 first, 2 middle, 3 last |
| ss_pid_ok | input | 1 | Data packet PID was a valid DATA PID |
| ss_crc_ok | input | 1 | High-speed CRC16 of the data packet was good |
| ss_timeout | input | 1 | Data packet did not arrive in time |
| ss_acc_o | output | 1 | Piece accepted into the start-split pipeline |
| ss_derr_o | output | 1 | Piece recorded as a downstream error |
| ss_ign_o | output | 1 | Piece dropped |
| ss_nostart_o | output | 1 | Rejected whole/first piece: do not start downstream |
| fs_bitstuff_o | output | NUM_EP | Per endpoint: force a bitstuff error on the open packet |

## Verification
Two functions can fall in the same cycle. One is the judgement of a piece and its effect on that endpoint's state. The other is the missed-microframe sweep at a boundary. The bench presents pieces in the very cycle of `uf_tick`, both for the endpoint whose silence is in question and for a different endpoint whose open packet was not served. It then expects the piece's own endpoint to count as heard and the other to raise its bitstuff bit. The next pieces for both endpoints show whether each was left open, or closed and dropping.

// File: rtl/iso_ss_pkg.sv
package iso_ss_pkg;

  typedef enum logic [1:0] {
    PART_ALL   = 2'd0,
    PART_BEGIN = 2'd1,
    PART_MID   = 2'd2,
    PART_END   = 2'd3
  } part_e;

  typedef enum logic [1:0] {
    VRD_IGN = 2'd0,
    VRD_ACC = 2'd1,
    VRD_ERR = 2'd2
  } verdict_e;

  typedef struct packed {
    logic  busy;   // packet open
    logic  seen;   // piece seen this microframe
    logic  mute;   // drop window open
    part_e last;   // last accepted position
  } ep_state_t;

endpackage

// File: rtl/iso_ss_judge.sv
module iso_ss_judge
  import iso_ss_pkg::*;
(
  input  part_e     part,
  input  logic      pid_ok,
  input  logic      crc_ok,
  input  logic      timeout,
  input  ep_state_t st,
  output verdict_e  verdict
);

  logic good;
  logic tail;
  logic cont_ok;

  always_comb begin
    good    = pid_ok && crc_ok && !timeout;
    tail    = (part == PART_MID) || (part == PART_END);
    cont_ok = st.busy && ((st.last == PART_BEGIN) || (st.last == PART_MID));
    verdict = VRD_ERR;
    if (tail && st.mute) begin
      verdict = VRD_IGN;
    end else if (good) begin
      unique case (part)
        PART_ALL, PART_BEGIN: verdict = st.busy ? VRD_ERR : VRD_ACC;
        PART_MID, PART_END:   verdict = cont_ok ? VRD_ACC : VRD_ERR;
        default:              verdict = VRD_ERR;
      endcase
    end
  end

endmodule

// File: rtl/iso_ss_ep_slot.sv
module iso_ss_ep_slot
  import iso_ss_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  verdict_e  verdict,
  input  part_e     part,
  input  logic      uf_tick,
  input  logic      clr_mute,
  output ep_state_t st,
  output logic      miss
);

  ep_state_t st_d;
  logic      upd_en;

  always_comb begin
    miss   = uf_tick && st.busy && !(st.seen || hit);
    upd_en = hit || uf_tick || clr_mute;
    st_d   = st;
    st_d.mute = st.mute && !clr_mute;
    if (hit) begin
      st_d.seen = 1'b1;
      unique case (verdict)
        VRD_ACC: begin
          if (part == PART_BEGIN) begin
            st_d.busy = 1'b1;
            st_d.last = PART_BEGIN;
          end else if (part == PART_MID) begin
            st_d.last = PART_MID;
          end else if (part == PART_END) begin
            st_d.busy = 1'b0;
            st_d.last = PART_END;
          end
        end
        VRD_ERR: begin
          st_d.busy = 1'b0;
          st_d.mute = 1'b1;
        end
        default: ;
      endcase
    end
    if (miss) begin
      st_d.busy = 1'b0;
      st_d.mute = 1'b1;
    end
    if (uf_tick) begin
      st_d.seen = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else if (upd_en) begin
      st <= st_d;
    end
  end

  AST_MISS_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    miss |=> (!st.busy && st.mute)); // R9

  AST_BEGIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && verdict == VRD_ACC && part == PART_BEGIN) |=> st.busy); // R3

  AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && verdict == VRD_ACC && part == PART_END) |=> !st.busy); // R5

  AST_ERR_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && verdict == VRD_ERR) |=> (!st.busy && st.mute)); // R6

endmodule

// File: rtl/iso_out_ss_seq.sv
module iso_out_ss_seq
  import iso_ss_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int EP_W   = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uf_tick,
  input  logic              ss_valid,
  input  logic [EP_W-1:0]   ss_ep,
  input  logic [1:0]        ss_part,
  input  logic              ss_pid_ok,
  input  logic              ss_crc_ok,
  input  logic              ss_timeout,
  output logic              ss_acc_o,
  output logic              ss_derr_o,
  output logic              ss_ign_o,
  output logic              ss_nostart_o,
  output logic [NUM_EP-1:0] fs_bitstuff_o
);

  part_e             part;
  ep_state_t         st_a [NUM_EP];
  ep_state_t         sel_st;
  verdict_e          verdict;
  logic [NUM_EP-1:0] hit_v;
  logic [NUM_EP-1:0] miss_v;
  logic              clr_mute;
  logic              head;
  logic              acc_d, err_d, ign_d, nostart_d;

  assign part = part_e'(ss_part);

  always_comb begin
    sel_st = '0;
    hit_v  = '0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (ss_ep == EP_W'(i)) begin
        sel_st   = st_a[i];
        hit_v[i] = ss_valid;
      end
    end
  end

  iso_ss_judge u_judge (
    .part    (part),
    .pid_ok  (ss_pid_ok),
    .crc_ok  (ss_crc_ok),
    .timeout (ss_timeout),
    .st      (sel_st),
    .verdict (verdict)
  );

  assign head     = (part == PART_ALL) || (part == PART_BEGIN);
  assign clr_mute = ss_valid && head;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
    iso_ss_ep_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit      (hit_v[g]),
      .verdict  (verdict),
      .part     (part),
      .uf_tick  (uf_tick),
      .clr_mute (clr_mute),
      .st       (st_a[g]),
      .miss     (miss_v[g])
    );
  end

  always_comb begin
    acc_d     = ss_valid && (hit_v != '0) && (verdict == VRD_ACC);
    err_d     = ss_valid && ((hit_v == '0) || (verdict == VRD_ERR));
    ign_d     = ss_valid && (hit_v != '0) && (verdict == VRD_IGN);
    nostart_d = err_d && head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_acc_o      <= 1'b0;
      ss_derr_o     <= 1'b0;
      ss_ign_o      <= 1'b0;
      ss_nostart_o  <= 1'b0;
      fs_bitstuff_o <= '0;
    end else begin
      ss_acc_o      <= acc_d;
      ss_derr_o     <= err_d;
      ss_ign_o      <= ign_d;
      ss_nostart_o  <= nostart_d;
      fs_bitstuff_o <= miss_v;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ss_acc_o, ss_derr_o, ss_ign_o})); // R12

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_valid |=> !(ss_acc_o || ss_derr_o || ss_ign_o)); // R12

  AST_NOSTART_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    ss_nostart_o |-> ss_derr_o); // R7

  AST_MUTED_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_valid && sel_st.mute && !head) |=> ss_ign_o); // R8

endmodule

// File: tb/test_iso_out_ss_seq.sv
module test_iso_out_ss_seq;

  localparam int NUM_EP = 4;
  localparam int EP_W   = 2;
  localparam int NVEC   = 28;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              uf_tick, ss_valid, ss_pid_ok, ss_crc_ok, ss_timeout;
  logic [EP_W-1:0]   ss_ep;
  logic [1:0]        ss_part;
  logic              ss_acc_o, ss_derr_o, ss_ign_o, ss_nostart_o;
  logic [NUM_EP-1:0] fs_bitstuff_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  iso_out_ss_seq #(.NUM_EP(NUM_EP), .EP_W(EP_W)) i_iso_out_ss_seq (
    .clk(clk), .rst_n(rst_n), .uf_tick(uf_tick), .ss_valid(ss_valid),
    .ss_ep(ss_ep), .ss_part(ss_part), .ss_pid_ok(ss_pid_ok),
    .ss_crc_ok(ss_crc_ok), .ss_timeout(ss_timeout), .ss_acc_o(ss_acc_o),
    .ss_derr_o(ss_derr_o), .ss_ign_o(ss_ign_o), .ss_nostart_o(ss_nostart_o),
    .fs_bitstuff_o(fs_bitstuff_o)
  );

  // {req, valid, ep, part, pid, crc, timeout, tick, acc, err, ign, nostart, bitstuff}
  function automatic logic [20:0] mk(input logic [3:0] r, input logic v,
      input logic [1:0] ep, input logic [1:0] pt, input logic pid,
      input logic crc, input logic to, input logic tk, input logic a,
      input logic e, input logic g, input logic n, input logic [3:0] b);
    return {r, v, ep, pt, pid, crc, to, tk, a, e, g, n, b};
  endfunction

  localparam logic [20:0] VEC [NVEC] = '{
    mk(2,  1,0,0,1,1,0,0, 1,0,0,0,4'h0), // R2 whole on idle ep0 accepted
    mk(3,  1,0,1,1,1,0,0, 1,0,0,0,4'h0), // R3 first opens ep0
    mk(2,  1,0,0,1,1,0,0, 0,1,0,1,4'h0), // R2 R7 whole on open ep0 rejected
    mk(8,  1,0,2,1,1,0,0, 0,0,1,0,4'h0), // R8 middle dropped
    mk(8,  1,0,3,1,1,0,0, 0,0,1,0,4'h0), // R8 last dropped
    mk(11, 1,1,1,1,1,0,0, 1,0,0,0,4'h0), // R11 R8 first on ep1 releases drops
    mk(4,  1,0,2,1,1,0,0, 0,1,0,0,4'h0), // R4 middle on idle ep0 is error
    mk(4,  1,1,2,1,1,0,0, 1,0,0,0,4'h0), // R4 middle after first
    mk(4,  1,1,2,1,1,0,0, 1,0,0,0,4'h0), // R4 middle after middle
    mk(5,  1,1,3,1,1,0,0, 1,0,0,0,4'h0), // R5 last closes ep1
    mk(5,  1,1,3,1,1,0,0, 0,1,0,0,4'h0), // R5 last on closed ep1 is error
    mk(6,  1,2,1,0,1,0,0, 0,1,0,1,4'h0), // R6 R7 bad PID on first
    mk(3,  1,2,1,1,1,0,0, 1,0,0,0,4'h0), // R3 first on ep2
    mk(6,  1,2,2,1,0,0,0, 0,1,0,0,4'h0), // R6 bad CRC on middle
    mk(8,  1,2,3,1,1,0,0, 0,0,1,0,4'h0), // R8 last dropped after error
    mk(3,  1,3,1,1,1,0,0, 1,0,0,0,4'h0), // R3 first on ep3
    mk(3,  1,3,1,1,1,0,0, 0,1,0,1,4'h0), // R3 second first is error
    mk(6,  1,3,0,1,1,1,0, 0,1,0,1,4'h0), // R6 timeout on whole
    mk(2,  1,3,0,1,1,0,0, 1,0,0,0,4'h0), // R2 whole accepted
    mk(10, 1,0,1,1,1,0,1, 1,0,0,0,4'h0), // R10 first on the boundary cycle
    mk(9,  0,0,0,0,0,0,1, 0,0,0,0,4'h1), // R9 ep0 silent for a microframe
    mk(9,  1,0,2,1,1,0,0, 0,0,1,0,4'h0), // R9 middle dropped after miss
    mk(11, 1,1,1,1,1,0,0, 1,0,0,0,4'h0), // R11 first on ep1
    mk(10, 1,2,1,1,1,0,1, 1,0,0,0,4'h0), // R10 ep1 heard, ep2 opens at tick
    mk(9,  1,1,2,1,1,0,1, 1,0,0,0,4'h4), // R9 R10 ep1 served, ep2 missed
    mk(5,  1,1,3,1,1,0,0, 1,0,0,0,4'h0), // R5 ep1 still open, closes
    mk(9,  1,2,2,1,1,0,0, 0,0,1,0,4'h0), // R9 ep2 dropping
    mk(12, 0,0,0,0,0,0,0, 0,0,0,0,4'h0)  // R12 no piece, no result
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {ss_acc_o, ss_derr_o, ss_ign_o, ss_nostart_o, fs_bitstuff_o};
  endfunction

  task automatic drive(input logic v, input logic [1:0] ep, input logic [1:0] pt,
      input logic pid, input logic crc, input logic to, input logic tk);
    @(negedge clk);
    ss_valid = v; ss_ep = ep; ss_part = pt; ss_pid_ok = pid;
    ss_crc_ok = crc; ss_timeout = to; uf_tick = tk;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0;
    uf_tick = 1'b0; ss_valid = 1'b0; ss_ep = '0; ss_part = '0;
    ss_pid_ok = 1'b0; ss_crc_ok = 1'b0; ss_timeout = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 outputs in reset", outs(), 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: whole piece right after reset is accepted
    drive(1, 0, 0, 1, 1, 0, 0);
    check("R1 whole after reset", outs(), 8'b1000_0000);

    for (int k = 0; k < NVEC; k++) begin
      drive(VEC[k][16], VEC[k][15:14], VEC[k][13:12], VEC[k][11],
            VEC[k][10], VEC[k][9], VEC[k][8]);
      checks++;
      if (outs() !== VEC[k][7:0]) begin
        failures++;
        $display("FAIL R%0d table row %0d actual=%b expected=%b",
                 VEC[k][20:17], k, outs(), VEC[k][7:0]);
      end
    end

    // R9: boundary with no open packet raises nothing
    drive(0, 0, 0, 0, 0, 0, 1);
    check("R9 boundary with all idle", outs(), 8'h00);

    // R1: reset while ep1 is open, then middle is error (not dropped)
    drive(1, 1, 1, 1, 1, 0, 0);
    check("R1 first before reset", outs(), 8'b1000_0000);
    @(negedge clk);
    ss_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 outputs cleared by reset", outs(), 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    drive(1, 1, 2, 1, 1, 0, 0);
    check("R1 middle after reset is error", outs(), 8'b0100_0000);

    // R11 R9: two endpoints open, only one served before boundary
    drive(1, 0, 1, 1, 1, 0, 0);
    drive(1, 3, 1, 1, 1, 0, 1);
    check("R11 first on ep3 at tick", outs(), 8'b1000_0000);
    drive(1, 3, 2, 1, 1, 0, 0);
    drive(0, 0, 0, 0, 0, 0, 1);
    check("R9 ep0 missed ep3 served", outs(), 8'b0000_0001);
    drive(1, 3, 3, 1, 1, 0, 0);
    check("R11 ep3 unaffected by ep0 miss", outs(), 8'b1000_0000);

    @(negedge clk);
    ss_valid = 1'b0; uf_tick = 1'b0;
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule